// File: doc/BRIEF.md
# Graphics Object Binding Validity Tracker

This block holds the two configuration words of one 2D rendering object: a state word (object class, color-key and clip flags, destination swizzle flag, selected 2D operation and the rendering-enabled flag) and a validity word (one bit per kind of helper object currently bound). Commands arrive one at a time on a valid/ready handshake. Each command carries a method code, the class of the rendering object it targets, and an 8-bit data value. For a set-operation command the data is the new operation. For a bind command the data is the class code of the object being bound; looking that code up in memory is done upstream.

A bind either sets the matching flag (the bound class is the one accepted code for that bind), clears it (the bound class is the null code 0x30), or is rejected. A rejected command leaves both words untouched and raises a one-cycle error pulse. After every accepted command the rendering-enabled bit is recomputed. The set of helper objects it requires depends on the selected operation and, for two legacy classes, on the class itself. Downstream rendering logic reads the enabled bit to decide whether the object may draw.

Top module: `gobj_tracker`

## Requirements
- R1: After reset, state_word and valid_word are all zero and cmd_err is low, so rendering is disabled.
- R2: Method 0 (set operation) writes data[2:0] into state_word bits 17:15. It is rejected when data is above 5, and also when data is above 2 and cmd_class is below 0x40.
- R3: State_word bit 24 (rendering enabled) has extra needs that depend on the operation. Operations 0 and 3 need nothing more. Operation 1 needs both valid_word bit 27 (pattern) and bit 28 (raster-op). Operation 2 needs bit 29 (single beta). Operations 4 and 5 need bit 30 (four-component beta).
- R4: Bit 24 also requires valid_word bit 25 (destination/color surface). When the stored class is 0x1F or 0x48 it further requires bit 26 (source/depth surface). Bit 24 is recomputed on every accepted command.
- R5: A bind whose data is 0x30 clears the flag that bind controls. A bind whose data is the bind's matching code sets that flag. Any other data rejects the command with no change to either word. Valid_word bits other than 25 to 30 stay zero.
- R6: Method 1 (plain 2D surface) with 0x42 sets bit 25 and clears state_word bit 14 (swizzle), and with 0x30 clears both bits. Method 2 (swizzle-capable 2D surface) behaves the same and also accepts 0x52, which sets both bit 25 and bit 14. Method 1 rejects 0x52.
- R7: The other binds set these valid_word bits. Method 3: 0x18 sets bit 27. Method 4: 0x44 sets bit 27. Method 5: 0x43 sets bit 28. Method 6: 0x12 sets bit 29. Method 7: 0x72 sets bit 30. Method 8: 0x58 sets bit 25. Method 9: 0x59 sets bit 26. Method 10: 0x5A sets bit 25. Method 11: 0x5B sets bit 26.
- R8: Method 12 (clip rectangle) with 0x19 sets state_word bit 13. Method 13 (color key) with 0x57 sets state_word bit 12, and it rejects 0x17.
- R9: cmd_ready is always high. An accepted command loads cmd_class into state_word bits 7:0. Its results appear one cycle after the accepting edge. cmd_err is a one-cycle pulse. Methods 14 and 15 are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command may be taken (always high) |
| cmd_method | input | 4 | Method code (see R2, R6 to R9) |
| cmd_class | input | 8 | Class of the rendering object targeted |
| cmd_data | input | 8 | Operation value or bound object's class |
| state_word | output | 32 | Object state word |
| valid_word | output | 32 | Bound-object validity word |
| cmd_err | output | 1 | One-cycle pulse for a rejected command |

## Verification
Every result of a command (both words and the error pulse) is due in the first cycle after the edge that accepts it. The bench drives each command on a falling edge and holds it for one rising edge. It compares all three outputs against its own model on the next falling edge, and at times it checks again one idle cycle later to confirm the error pulse has dropped and the words hold. Directed commands cover each operation's requirement set, the legacy-class rules, the swizzle forms and the rejected codes. About three thousand seeded random commands then mix methods, targets and bound codes.

// File: rtl/gobj_pkg.sv
package gobj_pkg;

    localparam int WORD_W   = 32;
    localparam int CLS_W    = 8;
    localparam int OP_W     = 3;

    // state word fields
    localparam int B_CHROMA = 12;
    localparam int B_CLIP   = 13;
    localparam int B_SWZ    = 14;
    localparam int OP_LSB   = 15;
    localparam int B_EN     = 24;

    // validity word fields
    localparam int B_DST    = 25;
    localparam int B_SRC    = 26;
    localparam int B_PAT    = 27;
    localparam int B_ROP    = 28;
    localparam int B_BETA1  = 29;
    localparam int B_BETA4  = 30;

    localparam logic [WORD_W-1:0] OP_MASK    = WORD_W'(((1 << OP_W) - 1) << OP_LSB);
    localparam logic [WORD_W-1:0] VAL_FIELDS = WORD_W'(32'h7E00_0000);

    // class codes
    localparam logic [CLS_W-1:0] C_NULL      = 8'h30;
    localparam logic [CLS_W-1:0] C_SURF2D    = 8'h42;
    localparam logic [CLS_W-1:0] C_SWZSURF   = 8'h52;
    localparam logic [CLS_W-1:0] C_PATT_OLD  = 8'h18;
    localparam logic [CLS_W-1:0] C_PATT_NEW  = 8'h44;
    localparam logic [CLS_W-1:0] C_ROP       = 8'h43;
    localparam logic [CLS_W-1:0] C_BETA1     = 8'h12;
    localparam logic [CLS_W-1:0] C_BETA4     = 8'h72;
    localparam logic [CLS_W-1:0] C_SURF_DST  = 8'h58;
    localparam logic [CLS_W-1:0] C_SURF_SRC  = 8'h59;
    localparam logic [CLS_W-1:0] C_SURF_COL  = 8'h5A;
    localparam logic [CLS_W-1:0] C_SURF_ZET  = 8'h5B;
    localparam logic [CLS_W-1:0] C_CLIPRECT  = 8'h19;
    localparam logic [CLS_W-1:0] C_CHROMA    = 8'h57;
    localparam logic [CLS_W-1:0] C_LEG_BLIT  = 8'h1F;
    localparam logic [CLS_W-1:0] C_LEG_TRI   = 8'h48;

    typedef enum logic [3:0] {
        M_SET_OP     = 4'd0,
        M_SURF2D     = 4'd1,
        M_SURF2D_SWZ = 4'd2,
        M_PATT_OLD   = 4'd3,
        M_PATT_NEW   = 4'd4,
        M_ROP        = 4'd5,
        M_BETA1      = 4'd6,
        M_BETA4      = 4'd7,
        M_SURF_DST   = 4'd8,
        M_SURF_SRC   = 4'd9,
        M_SURF_COL   = 4'd10,
        M_SURF_ZET   = 4'd11,
        M_CLIP       = 4'd12,
        M_CHROMA     = 4'd13
    } method_e;

    typedef struct packed {
        logic              accept;
        logic [WORD_W-1:0] ctx_mask;
        logic [WORD_W-1:0] ctx_set;
        logic [WORD_W-1:0] val_mask;
        logic [WORD_W-1:0] val_set;
    } upd_t;

    typedef struct packed {
        logic [WORD_W-1:0] ctx;
        logic [WORD_W-1:0] val;
        logic              err;
    } trk_t;

endpackage

// File: rtl/gobj_decode.sv
module gobj_decode
    import gobj_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int MAX_OP       = 5,
    parameter int LEGACY_LIMIT = 'h40,
    parameter int LEGACY_OPS   = 3
) (
    input  logic [3:0]       method,
    input  logic [CLS_W-1:0] obj_class,
    input  logic [DATA_W-1:0] data,
    output upd_t             upd
);

    logic             single_d;
    logic             on_ctx_d;
    logic [CLS_W-1:0] match_d;
    int               bitpos_d;
    logic [WORD_W-1:0] bit_mask;
    logic [CLS_W-1:0] bound;

    assign bound    = data[CLS_W-1:0];
    assign bit_mask = WORD_W'(1) << bitpos_d;

    // single-flag bind lookup
    always_comb begin
        single_d = 1'b1;
        on_ctx_d = 1'b0;
        match_d  = '0;
        bitpos_d = B_DST;
        case (method)
            M_PATT_OLD: begin match_d = C_PATT_OLD; bitpos_d = B_PAT;   end
            M_PATT_NEW: begin match_d = C_PATT_NEW; bitpos_d = B_PAT;   end
            M_ROP:      begin match_d = C_ROP;      bitpos_d = B_ROP;   end
            M_BETA1:    begin match_d = C_BETA1;    bitpos_d = B_BETA1; end
            M_BETA4:    begin match_d = C_BETA4;    bitpos_d = B_BETA4; end
            M_SURF_DST: begin match_d = C_SURF_DST; bitpos_d = B_DST;   end
            M_SURF_SRC: begin match_d = C_SURF_SRC; bitpos_d = B_SRC;   end
            M_SURF_COL: begin match_d = C_SURF_COL; bitpos_d = B_DST;   end
            M_SURF_ZET: begin match_d = C_SURF_ZET; bitpos_d = B_SRC;   end
            M_CLIP:     begin match_d = C_CLIPRECT; bitpos_d = B_CLIP;   on_ctx_d = 1'b1; end
            M_CHROMA:   begin match_d = C_CHROMA;   bitpos_d = B_CHROMA; on_ctx_d = 1'b1; end
            default:    single_d = 1'b0;
        endcase
    end

    always_comb begin
        upd = '0;
        if (method == M_SET_OP) begin
            if (32'(data) <= MAX_OP &&
                !(32'(data) >= LEGACY_OPS && 32'(obj_class) < LEGACY_LIMIT)) begin
                upd.accept   = 1'b1;
                upd.ctx_mask = OP_MASK;
                upd.ctx_set  = WORD_W'(data[OP_W-1:0]) << OP_LSB;
            end
        end else if (method == M_SURF2D || method == M_SURF2D_SWZ) begin
            upd.ctx_mask = WORD_W'(1) << B_SWZ;
            upd.val_mask = WORD_W'(1) << B_DST;
            if (bound == C_NULL) begin
                upd.accept = 1'b1;
            end else if (bound == C_SURF2D) begin
                upd.accept  = 1'b1;
                upd.val_set = WORD_W'(1) << B_DST;
            end else if (bound == C_SWZSURF && method == M_SURF2D_SWZ) begin
                upd.accept  = 1'b1;
                upd.val_set = WORD_W'(1) << B_DST;
                upd.ctx_set = WORD_W'(1) << B_SWZ;
            end
        end else if (single_d && (bound == C_NULL || bound == match_d)) begin
            upd.accept = 1'b1;
            if (on_ctx_d) begin
                upd.ctx_mask = bit_mask;
                upd.ctx_set  = (bound == match_d) ? bit_mask : '0;
            end else begin
                upd.val_mask = bit_mask;
                upd.val_set  = (bound == match_d) ? bit_mask : '0;
            end
        end
        if (!upd.accept) begin
            upd.ctx_mask = '0;
            upd.ctx_set  = '0;
            upd.val_mask = '0;
            upd.val_set  = '0;
        end
    end

endmodule

// File: rtl/gobj_enable.sv
module gobj_enable
    import gobj_pkg::*;
(
    input  logic [WORD_W-1:0] ctx,
    input  logic [WORD_W-1:0] val,
    output logic              en
);

    logic [OP_W-1:0]  op;
    logic [CLS_W-1:0] cls;
    logic             need_src;
    logic             op_ok;

    assign op       = ctx[OP_LSB +: OP_W];
    assign cls      = ctx[CLS_W-1:0];
    assign need_src = (cls == C_LEG_BLIT) || (cls == C_LEG_TRI);

    always_comb begin
        case (op)
            3'd0, 3'd3: op_ok = 1'b1;
            3'd1:       op_ok = val[B_PAT] & val[B_ROP];
            3'd2:       op_ok = val[B_BETA1];
            3'd4, 3'd5: op_ok = val[B_BETA4];
            default:    op_ok = 1'b0;
        endcase
    end

    assign en = val[B_DST] & (val[B_SRC] | ~need_src) & op_ok;

endmodule

// File: rtl/gobj_tracker.sv
module gobj_tracker
    import gobj_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int MAX_OP       = 5,
    parameter int LEGACY_LIMIT = 'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [3:0]        cmd_method,
    input  logic [CLS_W-1:0]  cmd_class,
    input  logic [DATA_W-1:0] cmd_data,
    output logic [WORD_W-1:0] state_word,
    output logic [WORD_W-1:0] valid_word,
    output logic              cmd_err
);

    trk_t              st_d, st_q;
    upd_t              upd;
    logic [WORD_W-1:0] ctx_pre, val_pre;
    logic              en_nx;
    logic              take;

    assign cmd_ready = 1'b1;
    assign take      = cmd_valid & cmd_ready;

    gobj_decode #(
        .DATA_W       (DATA_W),
        .MAX_OP       (MAX_OP),
        .LEGACY_LIMIT (LEGACY_LIMIT),
        .LEGACY_OPS   (3)
    ) u_dec (
        .method    (cmd_method),
        .obj_class (cmd_class),
        .data      (cmd_data),
        .upd       (upd)
    );

    always_comb begin
        ctx_pre = (st_q.ctx & ~upd.ctx_mask) | upd.ctx_set;
        ctx_pre[CLS_W-1:0] = cmd_class;
        val_pre = (st_q.val & ~upd.val_mask) | upd.val_set;
    end

    gobj_enable u_en (
        .ctx (ctx_pre),
        .val (val_pre),
        .en  (en_nx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (take) begin
            if (upd.accept) begin
                st_d.ctx        = ctx_pre;
                st_d.ctx[B_EN]  = en_nx;
                st_d.val        = val_pre;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign state_word = st_q.ctx;
    assign valid_word = st_q.val;
    assign cmd_err    = st_q.err;

    // R2
    op_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.ctx[OP_LSB +: OP_W]) <= MAX_OP);

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> ($stable(st_q.ctx) && $stable(st_q.val)));

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmd_valid) |-> ($stable(st_q.ctx) && $stable(st_q.val) && !st_q.err));

    // R4
    en_needs_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctx[B_EN] |-> st_q.val[B_DST]);

    // R3
    op1_needs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctx[B_EN] && st_q.ctx[OP_LSB +: OP_W] == 3'd1) |-> (st_q.val[B_PAT] && st_q.val[B_ROP]));

    // R5
    val_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.val & ~VAL_FIELDS) == '0);

endmodule

// File: tb/tb_gobj_tracker.sv
`timescale 1ns/1ps
module tb_gobj_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [3:0]  cmd_method = '0;
    logic [7:0]  cmd_class = '0;
    logic [7:0]  cmd_data = '0;
    logic [31:0] state_word, valid_word;
    logic        cmd_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] e_ctx = '0;
    logic [31:0] e_val = '0;
    logic        e_err = 1'b0;

    always #4 clk = ~clk;

    gobj_tracker dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_method(cmd_method), .cmd_class(cmd_class), .cmd_data(cmd_data),
        .state_word(state_word), .valid_word(valid_word), .cmd_err(cmd_err)
    );

    // expected enable, from R3 and R4
    function automatic logic exp_en(input logic [31:0] c, input logic [31:0] v);
        logic ok;
        logic [2:0] op = c[17:15];
        ok = v[25];
        if ((c[7:0] == 8'h1F || c[7:0] == 8'h48) && !v[26]) ok = 1'b0;
        if (op == 3'd1 && !(v[27] && v[28])) ok = 1'b0;
        if (op == 3'd2 && !v[29]) ok = 1'b0;
        if ((op == 3'd4 || op == 3'd5) && !v[30]) ok = 1'b0;
        if (op > 3'd5) ok = 1'b0;
        return ok;
    endfunction

    // model of one command from R2, R5 to R9; returns 1 on reject
    function automatic logic model(input logic [3:0] m, input logic [7:0] oc, input logic [7:0] d);
        logic [31:0] c = e_ctx;
        logic [31:0] v = e_val;
        logic        bad = 1'b0;
        logic [7:0]  code = 8'h00;
        int          pos = -1;
        bit          inctx = 1'b0;
        case (m)
            4'd0: begin
                if (d > 8'd5 || (d > 8'd2 && oc < 8'h40)) bad = 1'b1;
                else c[17:15] = d[2:0];
            end
            4'd1, 4'd2: begin
                if (d == 8'h30) begin v[25] = 1'b0; c[14] = 1'b0; end
                else if (d == 8'h42) begin v[25] = 1'b1; c[14] = 1'b0; end
                else if (d == 8'h52 && m == 4'd2) begin v[25] = 1'b1; c[14] = 1'b1; end
                else bad = 1'b1;
            end
            4'd3:  begin code = 8'h18; pos = 27; end
            4'd4:  begin code = 8'h44; pos = 27; end
            4'd5:  begin code = 8'h43; pos = 28; end
            4'd6:  begin code = 8'h12; pos = 29; end
            4'd7:  begin code = 8'h72; pos = 30; end
            4'd8:  begin code = 8'h58; pos = 25; end
            4'd9:  begin code = 8'h59; pos = 26; end
            4'd10: begin code = 8'h5A; pos = 25; end
            4'd11: begin code = 8'h5B; pos = 26; end
            4'd12: begin code = 8'h19; pos = 13; inctx = 1'b1; end
            4'd13: begin code = 8'h57; pos = 12; inctx = 1'b1; end
            default: bad = 1'b1;
        endcase
        if (pos >= 0) begin
            if (d == 8'h30 || d == code) begin
                if (inctx) c[pos] = (d == code);
                else       v[pos] = (d == code);
            end else bad = 1'b1;
        end
        if (!bad) begin
            c[7:0]  = oc;
            c[24]   = exp_en(c, v);
            e_ctx   = c;
            e_val   = v;
        end
        return bad;
    endfunction

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] m, input logic [7:0] oc, input logic [7:0] d, input string tag);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_method = m;
        cmd_class  = oc;
        cmd_data   = d;
        e_err      = model(m, oc, d);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmp(tag, "state_word", state_word, e_ctx);
        cmp(tag, "valid_word", valid_word, e_val);
        cmp(tag, "cmd_err", {31'b0, cmd_err}, {31'b0, e_err});
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        cmp(tag, "cmd_err idle", {31'b0, cmd_err}, 32'd0);
        cmp(tag, "state_word idle", state_word, e_ctx);
        cmp(tag, "valid_word idle", valid_word, e_val);
    endtask

    logic [7:0] tgt_pool [7] = '{8'h1F, 8'h48, 8'h5F, 8'h4B, 8'h21, 8'h60, 8'h77};
    logic [7:0] bnd_pool [16] = '{8'h30, 8'h42, 8'h52, 8'h18, 8'h44, 8'h43, 8'h12, 8'h72,
                                  8'h58, 8'h59, 8'h5A, 8'h5B, 8'h19, 8'h57, 8'h17, 8'h30};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0_FFEE));
        repeat (3) @(negedge clk);
        // R1 reset state
        cmp("R1", "state_word", state_word, 32'h0);
        cmp("R1", "valid_word", valid_word, 32'h0);
        cmp("R1", "cmd_err", {31'b0, cmd_err}, 32'd0);
        cmp("R9", "cmd_ready", {31'b0, cmd_ready}, 32'd1);
        rst_n = 1'b1;
        idle_check("R1");

        // R2 operation range and legacy limit
        send(4'd0, 8'h5F, 8'd5, "R2");
        send(4'd0, 8'h5F, 8'd6, "R2");
        idle_check("R9");
        send(4'd0, 8'h1F, 8'd3, "R2");
        send(4'd0, 8'h1F, 8'd2, "R2");
        send(4'd0, 8'h3F, 8'd5, "R2");
        send(4'd0, 8'h40, 8'd4, "R2");

        // R3 op 4 needs beta4; R6 plain 2D surface
        send(4'd1, 8'h5F, 8'h42, "R6");
        send(4'd7, 8'h5F, 8'h72, "R3");
        send(4'd1, 8'h5F, 8'h52, "R6");
        send(4'd2, 8'h5F, 8'h52, "R6");
        send(4'd2, 8'h5F, 8'h42, "R6");
        send(4'd2, 8'h5F, 8'h52, "R6");
        send(4'd1, 8'h5F, 8'h30, "R6");
        send(4'd8, 8'h5F, 8'h58, "R7");

        // R3 op 1 needs pattern and raster-op together
        send(4'd0, 8'h5F, 8'd1, "R3");
        send(4'd4, 8'h5F, 8'h44, "R3");
        send(4'd5, 8'h5F, 8'h43, "R3");
        send(4'd3, 8'h5F, 8'h44, "R5");
        send(4'd3, 8'h5F, 8'h30, "R5");
        send(4'd3, 8'h5F, 8'h18, "R7");
        // R3 op 2 and op 3
        send(4'd0, 8'h5F, 8'd2, "R3");
        send(4'd6, 8'h5F, 8'h12, "R3");
        send(4'd0, 8'h5F, 8'd3, "R3");

        // R4 legacy classes need the source surface
        send(4'd0, 8'h1F, 8'd0, "R4");
        send(4'd9, 8'h1F, 8'h59, "R4");
        send(4'd11, 8'h48, 8'h30, "R4");
        send(4'd11, 8'h48, 8'h5B, "R7");
        send(4'd10, 8'h48, 8'h30, "R4");
        send(4'd10, 8'h48, 8'h5A, "R7");

        // R8 clip and color key
        send(4'd12, 8'h5F, 8'h19, "R8");
        send(4'd13, 8'h5F, 8'h17, "R8");
        send(4'd13, 8'h5F, 8'h57, "R8");
        send(4'd12, 8'h5F, 8'h30, "R8");
        // R9 undefined methods
        send(4'd14, 8'h5F, 8'h30, "R9");
        send(4'd15, 8'h5F, 8'h57, "R9");
        idle_check("R9");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] m  = 4'($urandom_range(0, 15));
            logic [7:0] oc = ($urandom_range(0, 7) == 0) ? 8'($urandom) : tgt_pool[$urandom_range(0, 6)];
            logic [7:0] d;
            if (m == 4'd0) d = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'($urandom_range(0, 7));
            else d = ($urandom_range(0, 9) == 0) ? 8'($urandom) : bnd_pool[$urandom_range(0, 15)];
            send(m, oc, d, "R5");
            if ($urandom_range(0, 7) == 0) idle_check("R9");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule